// File: doc/BRIEF.md
# Event Counter Box with Freeze and Overflow Status

This block is a small performance-monitoring unit with four generic 64-bit event counters. Each counter has its own control register, which chooses one of several incoming per-cycle event-count inputs and shapes it. Shaping can pass the raw count through, count cycles at or above a threshold, or count only rising edges of the event condition. A box-level control register can freeze all counting at once and can clear, in bulk, either every counter or every control register. A box-level status register keeps a sticky overflow flag per counter, which software clears by writing 1 to it.

Software reaches all state through a plain register port. A write with an 8-bit byte offset completes on the clock edge. Reads are combinational on the offset. The event inputs carry a per-cycle count for each source, and they are sampled on every clock. No stream of data enters or leaves the block, so there is no valid/ready handshake: the register port and the event inputs are plain control pins, and the block never stalls the writer.

Top module: `pmon_box`

## Requirements
- R1: The counters are read and written at byte offsets 0xA0, 0xB0, 0xB8 and 0xC0, in that order for counters 0 to 3. Each is 64 bits wide. A software write loads the written value, and it wins over an increment in the same cycle.
- R2: The control register of counter i sits at offset 0xD8 + 4*i. Its fields are: event select in bits 7:0, unit mask in bits 15:8, edge detect in bit 18, enable in bit 22 and threshold in bits 31:24. Event select k picks event input k, which is bits 4k+3:4k of `evt_cnt_i`. A select of 8 or more picks a constant zero. With enable 1, threshold 0 and edge detect 0, the counter adds the selected raw count on each clock.
- R3: The box control register is at offset 0xF4. While its bit 8 (freeze) is 1, no counter counts events. Software writes and resets still apply. Bit 8 reads back as written.
- R4: Writing 1 to bit 1 of the box control register sets all four counters to zero on that edge. The bit reads as 0.
- R5: Writing 1 to bit 0 of the box control register sets all four control registers to zero on that edge. The bit reads as 0.
- R6: The status register is at offset 0xF8. Bit i is set when counter i wraps past all-ones while counting, and the bit stays set until it is cleared.
- R7: A write to the status register clears each flag whose written bit is 1 and leaves each flag whose written bit is 0 unchanged.
- R8: When a counter wraps in the same cycle that software writes 1 to its flag, the flag ends up 1.
- R9: With a nonzero threshold and edge detect off, the counter adds 1 on each cycle where the selected count is greater than or equal to the threshold, and adds nothing on other cycles.
- R10: With edge detect on, the counter adds 1 only on a cycle where the event condition is true and was false on the previous clock. The event condition is count >= threshold when the threshold is nonzero, and count != 0 otherwise.
- R11: Writing a control register with bit 17 set zeroes that counter only. Bit 17 reads as 0.
- R12: Ignored and reserved bits, and offsets that map to no register, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| evt_cnt_i | input | NUM_EVENTS*EVT_W (32) | Per-cycle event counts, 4 bits per source |

## Verification
Counting is tried with raw multi-valued counts on one source, and with a stream of counts that crosses a threshold. These two separate adding the value from adding one. A run of repeated nonzero counts, then a gap, then a nonzero count distinguishes edge mode from level mode. Counters preloaded near all-ones are used to force wraps, alone and in the same cycle as a status clear, so that the set-wins order is observed. A long seeded random run mixes events, freeze, bulk resets and register writes. It covers collisions that the directed cases miss, such as a reset arriving in the same cycle as an increment or a wrap.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int NUM_CTRS = 4;
  localparam int CTL_W    = 32;

  localparam logic [7:0] BOX_CTL_OFF  = 8'hF4;
  localparam logic [7:0] BOX_STAT_OFF = 8'hF8;

  localparam int FRZ_BIT      = 8;
  localparam int RST_CNT_BIT  = 1;
  localparam int RST_CTL_BIT  = 0;
  localparam int CLR_ONE_BIT  = 17;
  localparam int EDGE_BIT     = 18;
  localparam int EN_BIT       = 22;

  typedef struct packed {
    logic [7:0] thresh;
    logic       en;
    logic       edge_en;
    logic [7:0] umask;
    logic [7:0] sel;
  } ctl_t;

  function automatic logic [7:0] ctr_off(input int i);
    case (i)
      0:       return 8'hA0;
      1:       return 8'hB0;
      2:       return 8'hB8;
      default: return 8'hC0;
    endcase
  endfunction

  function automatic logic [7:0] ctl_off(input int i);
    return 8'(216 + 4 * i);
  endfunction

  function automatic ctl_t ctl_from_word(input logic [CTL_W-1:0] w);
    ctl_t c;
    c.sel     = w[7:0];
    c.umask   = w[15:8];
    c.edge_en = w[EDGE_BIT];
    c.en      = w[EN_BIT];
    c.thresh  = w[31:24];
    return c;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_to_word(input ctl_t c);
    logic [CTL_W-1:0] w;
    w           = '0;
    w[7:0]      = c.sel;
    w[15:8]     = c.umask;
    w[EDGE_BIT] = c.edge_en;
    w[EN_BIT]   = c.en;
    w[31:24]    = c.thresh;
    return w;
  endfunction
endpackage

// File: rtl/pmon_evt_shaper.sv
module pmon_evt_shaper
  import pmon_pkg::*;
#(
  parameter int EVT_W      = 4,
  parameter int NUM_EVENTS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_EVENTS*EVT_W-1:0] evt_flat,
  input  ctl_t                        ctl,
  output logic [EVT_W-1:0]            inc_o
);
  logic [EVT_W-1:0] raw;
  logic [7:0]       raw8;
  logic             cond;
  logic             cond_prev_q;

  always_comb begin
    raw = '0;
    for (int k = 0; k < NUM_EVENTS; k++) begin
      if (ctl.sel == 8'(k)) raw = evt_flat[k*EVT_W +: EVT_W];
    end
  end

  assign raw8 = 8'(raw);
  assign cond = (ctl.thresh != 8'd0) ? (raw8 >= ctl.thresh) : (raw != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_prev_q <= 1'b0;
    else        cond_prev_q <= cond;
  end

  always_comb begin
    if (ctl.edge_en)
      inc_o = {{(EVT_W-1){1'b0}}, cond & ~cond_prev_q};
    else if (ctl.thresh != 8'd0)
      inc_o = {{(EVT_W-1){1'b0}}, cond};
    else
      inc_o = raw;
  end
endmodule

// File: rtl/pmon_ctr_slice.sv
module pmon_ctr_slice
  import pmon_pkg::*;
#(
  parameter int CNT_W      = 64,
  parameter int EVT_W      = 4,
  parameter int NUM_EVENTS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctl_we,
  input  logic                        ctl_clr,
  input  logic                        ctr_we,
  input  logic                        ctr_clr,
  input  logic                        frozen,
  input  logic [CNT_W-1:0]            wdata,
  input  logic [NUM_EVENTS*EVT_W-1:0] evt_flat,
  output ctl_t                        ctl_q,
  output logic [CNT_W-1:0]            count_q,
  output logic                        wrap_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [EVT_W-1:0] inc;
  logic [SUM_W-1:0] sum;
  logic             active;
  logic             zero_now;

  pmon_evt_shaper #(.EVT_W(EVT_W), .NUM_EVENTS(NUM_EVENTS)) shaper_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_flat (evt_flat),
    .ctl      (ctl_q),
    .inc_o    (inc)
  );

  assign active   = ctl_q.en & ~frozen;
  assign zero_now = ctr_clr | (ctl_we & wdata[CLR_ONE_BIT]);
  assign sum      = {1'b0, count_q} + {{(SUM_W-EVT_W){1'b0}}, inc};
  assign wrap_o   = active & sum[CNT_W] & ~zero_now & ~ctr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= '0;
    else if (ctl_clr) ctl_q <= '0;
    else if (ctl_we)  ctl_q <= ctl_from_word(wdata[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (zero_now) count_q <= '0;
    else if (ctr_we)   count_q <= wdata;
    else if (active)   count_q <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/pmon_box.sv
module pmon_box
  import pmon_pkg::*;
#(
  parameter int CNT_W      = 64,
  parameter int EVT_W      = 4,
  parameter int NUM_EVENTS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr_en,
  input  logic [7:0]                  reg_addr,
  input  logic [CNT_W-1:0]            reg_wdata,
  output logic [CNT_W-1:0]            reg_rdata,
  input  logic [NUM_EVENTS*EVT_W-1:0] evt_cnt_i
);
  logic                      box_wr;
  logic                      stat_wr;
  logic                      frz_q;
  logic [NUM_CTRS-1:0]       ovf_q;
  logic [NUM_CTRS-1:0]       ovf_set;
  logic [NUM_CTRS-1:0]       ctl_we;
  logic [NUM_CTRS-1:0]       ctr_we;
  logic [NUM_CTRS*CNT_W-1:0] cnt_flat;
  logic [NUM_CTRS*CTL_W-1:0] ctl_flat;
  ctl_t                      ctl_q [NUM_CTRS];
  logic [CNT_W-1:0]          cnt_q [NUM_CTRS];

  assign box_wr  = reg_wr_en & (reg_addr == BOX_CTL_OFF);
  assign stat_wr = reg_wr_en & (reg_addr == BOX_STAT_OFF);

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_slice
    assign ctl_we[i] = reg_wr_en & (reg_addr == ctl_off(i));
    assign ctr_we[i] = reg_wr_en & (reg_addr == ctr_off(i));

    pmon_ctr_slice #(.CNT_W(CNT_W), .EVT_W(EVT_W), .NUM_EVENTS(NUM_EVENTS)) slice_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we[i]),
      .ctl_clr  (box_wr & reg_wdata[RST_CTL_BIT]),
      .ctr_we   (ctr_we[i]),
      .ctr_clr  (box_wr & reg_wdata[RST_CNT_BIT]),
      .frozen   (frz_q),
      .wdata    (reg_wdata),
      .evt_flat (evt_cnt_i),
      .ctl_q    (ctl_q[i]),
      .count_q  (cnt_q[i]),
      .wrap_o   (ovf_set[i])
    );

    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];
    assign ctl_flat[i*CTL_W +: CTL_W] = ctl_to_word(ctl_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frz_q <= 1'b0;
    else if (box_wr) frz_q <= reg_wdata[FRZ_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= (ovf_q & ~({NUM_CTRS{stat_wr}} & reg_wdata[NUM_CTRS-1:0])) | ovf_set;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (reg_addr == ctr_off(i)) reg_rdata = cnt_q[i];
      if (reg_addr == ctl_off(i)) reg_rdata = CNT_W'(ctl_flat[i*CTL_W +: CTL_W]);
    end
    if (reg_addr == BOX_CTL_OFF)  reg_rdata[FRZ_BIT] = frz_q;
    if (reg_addr == BOX_STAT_OFF) reg_rdata[NUM_CTRS-1:0] = ovf_q;
  end
endmodule

// File: rtl/pmon_box_chk.sv
module pmon_box_chk
  import pmon_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reg_wr_en,
  input logic [7:0]                reg_addr,
  input logic [CNT_W-1:0]          reg_wdata,
  input logic [CNT_W-1:0]          reg_rdata,
  input logic                      frz_q,
  input logic [NUM_CTRS-1:0]       ovf_q,
  input logic [NUM_CTRS-1:0]       ovf_set,
  input logic [NUM_CTRS*CNT_W-1:0] cnt_flat,
  input logic [NUM_CTRS*CTL_W-1:0] ctl_flat
);
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !reg_wr_en) |=> $stable(cnt_flat)); // R3

  AST_BULK_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == BOX_CTL_OFF && reg_wdata[RST_CNT_BIT]) |=> (cnt_flat == '0)); // R4

  AST_BULK_CTL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == BOX_CTL_OFF && reg_wdata[RST_CTL_BIT]) |=> (ctl_flat == '0)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_addr == BOX_STAT_OFF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set != '0) |=> ((ovf_q & $past(ovf_set)) == $past(ovf_set))); // R8

  AST_BOXCTL_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == BOX_CTL_OFF) |-> ((reg_rdata & ~(CNT_W'(1) << FRZ_BIT)) == '0)); // R12
endmodule

bind pmon_box pmon_box_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .frz_q     (frz_q),
  .ovf_q     (ovf_q),
  .ovf_set   (ovf_set),
  .cnt_flat  (cnt_flat),
  .ctl_flat  (ctl_flat)
);

// File: tb/pmon_box_tb.sv
`timescale 1ns/100ps
module pmon_box_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [31:0] evt_cnt_i = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc_cnt = 0;

  always #10 clk = ~clk;

  pmon_box dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_cnt_i (evt_cnt_i)
  );

  // Expected state built from the requirements
  logic [63:0] m_cnt  [4];
  logic [7:0]  m_sel  [4];
  logic [7:0]  m_um   [4];
  logic [7:0]  m_thr  [4];
  logic        m_edge [4];
  logic        m_en   [4];
  logic        m_prev [4];
  logic        m_frz;
  logic [3:0]  m_ovf;

  function automatic logic [7:0] cnt_addr(input int i);
    case (i) 0: return 8'hA0; 1: return 8'hB0; 2: return 8'hB8; default: return 8'hC0; endcase
  endfunction

  function automatic logic [7:0] ctl_addr(input int i);
    return 8'(8'hD8 + 4 * i);
  endfunction

  function automatic logic [31:0] ev_put(input int ch, input int val);
    return 32'(val & 15) << (4 * ch);
  endfunction

  function automatic logic [63:0] exp_read(input logic [7:0] a);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      if (a == cnt_addr(i)) r = m_cnt[i];
      if (a == ctl_addr(i))
        r = {32'd0, m_thr[i], 1'b0, m_en[i], 3'b000, m_edge[i], 2'b00, m_um[i], m_sel[i]};
    end
    if (a == 8'hF4) r[8] = m_frz;
    if (a == 8'hF8) r[3:0] = m_ovf;
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = '0; m_sel[i] = '0; m_um[i] = '0; m_thr[i] = '0;
      m_edge[i] = 1'b0; m_en[i] = 1'b0; m_prev[i] = 1'b0;
    end
    m_frz = 1'b0;
    m_ovf = '0;
  endtask

  task automatic model_step(input logic wr, input logic [7:0] a, input logic [63:0] d,
                            input logic [31:0] ev);
    logic [3:0]  wrap;
    logic        box_w;
    box_w = wr && a == 8'hF4;
    wrap  = '0;
    for (int i = 0; i < 4; i++) begin
      int raw; logic cond; int inc; logic [64:0] s; logic act;
      raw  = (m_sel[i] < 8) ? int'(ev[4*m_sel[i] +: 4]) : 0;
      cond = (m_thr[i] != 0) ? (raw >= int'(m_thr[i])) : (raw != 0);
      if (m_edge[i])          inc = (cond && !m_prev[i]) ? 1 : 0;
      else if (m_thr[i] != 0) inc = cond ? 1 : 0;
      else                    inc = raw;
      m_prev[i] = cond;
      act = m_en[i] && !m_frz;
      s = {1'b0, m_cnt[i]} + 65'(inc);
      if (box_w && d[1])                           m_cnt[i] = '0;
      else if (wr && a == ctl_addr(i) && d[17])    m_cnt[i] = '0;
      else if (wr && a == cnt_addr(i))             m_cnt[i] = d;
      else if (act) begin
        m_cnt[i] = s[63:0];
        wrap[i]  = s[64];
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (box_w && d[0]) begin
        m_sel[i] = '0; m_um[i] = '0; m_thr[i] = '0; m_edge[i] = 1'b0; m_en[i] = 1'b0;
      end else if (wr && a == ctl_addr(i)) begin
        m_sel[i] = d[7:0]; m_um[i] = d[15:8]; m_thr[i] = d[31:24];
        m_edge[i] = d[18]; m_en[i] = d[22];
      end
    end
    if (box_w) m_frz = d[8];
    m_ovf = (m_ovf & ~((wr && a == 8'hF8) ? d[3:0] : 4'h0)) | wrap;
  endtask

  task automatic tick(input logic wr, input logic [7:0] a, input logic [63:0] d,
                      input logic [31:0] ev);
    @(negedge clk);
    reg_wr_en = wr; reg_addr = a; reg_wdata = d; evt_cnt_i = ev;
    model_step(wr, a, d, ev);
    @(posedge clk);
    #2;
    reg_wr_en = 1'b0; evt_cnt_i = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(1'b0, 8'h00, '0, '0);
  endtask

  task automatic chk_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_lit(input string tag, input logic [7:0] a, input logic [63:0] exp);
    reg_addr = a;
    #0.5;
    chk_val(tag, reg_rdata, exp);
  endtask

  task automatic rd_model(input string tag, input logic [7:0] a);
    reg_addr = a;
    #0.5;
    chk_val(tag, reg_rdata, exp_read(a));
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      rd_model({tag, " R1 counter"}, cnt_addr(i));
      rd_model({tag, " R2 control"}, ctl_addr(i));
    end
    rd_model({tag, " R3 box control"}, 8'hF4);
    rd_model({tag, " R6 status"}, 8'hF8);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt >= 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    logic [31:0] ev;
    model_reset();
    #45 rst_n = 1'b1;

    // reset state
    rd_lit("R1 reset counter0", 8'hA0, '0);
    rd_lit("R6 reset status", 8'hF8, '0);
    rd_lit("R12 unmapped offset", 8'h10, '0);
    check_all("reset");

    // R2 raw counting on source 2
    tick(1'b1, 8'hD8, 64'h0040_0002, '0);
    tick(1'b0, 8'h00, '0, ev_put(2, 3));
    tick(1'b0, 8'h00, '0, ev_put(2, 5) | ev_put(1, 9));
    rd_lit("R2 raw sum", 8'hA0, 64'd8);

    // R1 software load wins over increment
    tick(1'b1, 8'hA0, 64'h1234_5678_9ABC_DEF0, ev_put(2, 7));
    rd_lit("R1 load wins", 8'hA0, 64'h1234_5678_9ABC_DEF0);

    // R9 threshold 3 on source 4
    tick(1'b1, 8'hE0, 64'h0340_0004, '0);
    tick(1'b1, 8'hB8, 64'd0, '0);
    tick(1'b0, 8'h00, '0, ev_put(4, 2));
    tick(1'b0, 8'h00, '0, ev_put(4, 3));
    tick(1'b0, 8'h00, '0, ev_put(4, 7));
    tick(1'b0, 8'h00, '0, ev_put(4, 1));
    rd_lit("R9 threshold count", 8'hB8, 64'd2);

    // R10 edge detect on source 1
    tick(1'b1, 8'hE4, 64'h0044_0001, '0);
    tick(1'b0, 8'h00, '0, ev_put(1, 2));
    tick(1'b0, 8'h00, '0, ev_put(1, 2));
    tick(1'b0, 8'h00, '0, ev_put(1, 3));
    tick(1'b0, 8'h00, '0, '0);
    tick(1'b0, 8'h00, '0, ev_put(1, 1));
    rd_lit("R10 edge count", 8'hC0, 64'd2);

    // R3 freeze
    tick(1'b1, 8'hF4, 64'h100, '0);
    rd_lit("R3 freeze reads back", 8'hF4, 64'h100);
    tick(1'b0, 8'h00, '0, ev_put(2, 6) | ev_put(1, 4));
    tick(1'b0, 8'h00, '0, ev_put(2, 6));
    rd_lit("R3 frozen counter0", 8'hA0, 64'h1234_5678_9ABC_DEF0);
    tick(1'b1, 8'hF4, 64'h0, '0);
    tick(1'b0, 8'h00, '0, ev_put(2, 1));
    rd_lit("R3 unfrozen counter0", 8'hA0, 64'h1234_5678_9ABC_DEF1);

    // R6 wrap sets flag, R7 write-1-to-clear
    tick(1'b1, 8'hA0, 64'hFFFF_FFFF_FFFF_FFFE, '0);
    tick(1'b0, 8'h00, '0, ev_put(2, 3));
    rd_lit("R6 wrapped value", 8'hA0, 64'd1);
    rd_lit("R6 flag set", 8'hF8, 64'h1);
    idle(2);
    rd_lit("R6 flag sticky", 8'hF8, 64'h1);
    tick(1'b1, 8'hF8, 64'hE, '0);
    rd_lit("R7 write 0 keeps flag", 8'hF8, 64'h1);
    tick(1'b1, 8'hF8, 64'h1, '0);
    rd_lit("R7 write 1 clears flag", 8'hF8, 64'h0);

    // R8 set wins over clear in same cycle (counter1, raw source 0)
    tick(1'b1, 8'hDC, 64'h0040_0000, '0);
    tick(1'b1, 8'hB0, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    tick(1'b1, 8'hF8, 64'hF, ev_put(0, 1));
    rd_lit("R8 set wins", 8'hF8, 64'h2);

    // R11 single counter reset through its control register
    tick(1'b1, 8'hA0, 64'd77, '0);
    tick(1'b1, 8'hB0, 64'd55, '0);
    tick(1'b1, 8'hD8, 64'h0042_0002, '0);
    rd_lit("R11 counter0 zeroed", 8'hA0, 64'd0);
    rd_lit("R11 counter1 kept", 8'hB0, 64'd55);
    rd_lit("R11 bit reads zero", 8'hD8, 64'h0040_0002);

    // R12 reserved bits, out-of-range select
    tick(1'b1, 8'hE0, 64'hFFFF_FFFF_FFFF_FFFF, '0);
    rd_lit("R12 control mask", 8'hE0, 64'hFF44_FFFF);
    tick(1'b1, 8'hF4, 64'hFFFF_FFFF_FFFF_FEFC, '0);
    rd_lit("R12 box control mask", 8'hF4, 64'h0);

    // R4 bulk counter clear, R5 bulk control clear
    tick(1'b1, 8'hC0, 64'd9, '0);
    tick(1'b1, 8'hF4, 64'h2, '0);
    for (int i = 0; i < 4; i++) rd_lit("R4 counter cleared", cnt_addr(i), 64'd0);
    tick(1'b1, 8'hF4, 64'h1, '0);
    for (int i = 0; i < 4; i++) rd_lit("R5 control cleared", ctl_addr(i), 64'd0);
    check_all("directed");

    // constrained random mix with fixed seed
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  a;
      logic [63:0] d;
      logic        w;
      int          pick;
      ev = '0;
      for (int ch = 0; ch < 8; ch++) if ($urandom_range(0, 2) != 0) ev |= ev_put(ch, $urandom_range(0, 15));
      w = ($urandom_range(0, 5) == 0);
      a = 8'h00; d = '0;
      if (w) begin
        pick = $urandom_range(0, 9);
        if (pick < 3) begin
          a = ctl_addr($urandom_range(0, 3));
          d = {$urandom, $urandom};
          d[22] = ($urandom_range(0, 4) != 0);
          d[7:0] = 8'($urandom_range(0, 9));
          d[17] = ($urandom_range(0, 7) == 0);
          d[31:24] = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom_range(1, 12));
        end else if (pick < 6) begin
          a = cnt_addr($urandom_range(0, 3));
          d = 64'hFFFF_FFFF_FFFF_FFFF - 64'($urandom_range(0, 40));
        end else if (pick < 8) begin
          a = 8'hF8;
          d = 64'($urandom_range(0, 15));
        end else begin
          a = 8'hF4;
          d = 64'($urandom_range(0, 1)) << 8;
          if ($urandom_range(0, 5) == 0) d[1] = 1'b1;
          if ($urandom_range(0, 9) == 0) d[0] = 1'b1;
        end
      end
      tick(w, a, d, ev);
      if ((n % 16) == 15) check_all("random");
    end
    check_all("final");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule